// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two single-precision floating-point operands and returns the single-precision result. The operation runs through a four-stage pipeline: exponent comparison, alignment of the smaller mantissa, magnitude add or subtract, and normalization. A register closes each stage. The block accepts a new operation on every clock and produces each result a fixed four cycles later. A valid flag travels with the data.

Addition and subtraction share one datapath. A subtract request inverts the sign of operand B, and the magnitude unit then adds or subtracts mantissas according to the effective signs. The arithmetic is deliberately reduced. Operands with a zero exponent field count as zero, and an exponent field of all ones is handled like any other exponent. Results are truncated toward zero, exponent overflow saturates to a signed infinity, and exponent underflow flushes to +0. The block suits a butterfly datapath that needs throughput and a short, fixed latency more than full standard compliance.

Top module: `fp_add_pipe`

## Requirements
- R1: Both operands and the result use the 32-bit layout sign in bit 31, biased exponent (bias 127) in bits 30..23 and fraction in bits 22..0. The block returns A+B when `in_sub` is 0 and A-B when `in_sub` is 1.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high and `out_res` carries that operation's result after exactly four rising edges. A new operation is accepted on every edge. Synchronous reset clears `out_valid`.
- R3: The operand with the larger exponent field sets the result exponent. When both exponents are equal and the effective signs differ, the result takes the sign of the operand with the larger mantissa (B's effective sign when B's mantissa is larger).
- R4: The mantissa of the smaller operand, with its hidden bit, is shifted right by the exponent difference and truncated. A difference of 25 or more reduces it to zero, so the result equals the larger operand.
- R5: A carry out of the magnitude addition shifts the mantissa right by one place and increments the exponent. The dropped bit is discarded (truncation, no rounding).
- R6: After a magnitude subtraction, leading zeros are removed by a left shift until the hidden bit is set, and the exponent is reduced by the shift count.
- R7: An exact zero result is 0x00000000 (+0) whatever the operand signs. An operand whose exponent field is 0 acts as zero whatever its fraction.
- R8: A result whose exponent would reach 255 or more becomes an infinity (exponent 255, fraction 0) with the result's sign.
- R9: A result whose exponent would be 0 or less is flushed to 0x00000000.
- R10: A cycle with `in_valid` low produces a cycle with `out_valid` low four edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs |
| in_a | input | 32 | Operand A, single precision |
| in_b | input | 32 | Operand B, single precision |
| in_sub | input | 1 | 0 selects A+B, 1 selects A-B |
| out_valid | output | 1 | Result present on `out_res` |
| out_res | output | 32 | Result, single precision |

## Verification
The bench targets several corner cases:
- Equal exponents with opposite effective signs, where a design that never compared mantissas would return a result with the wrong sign.
- Carry out of the addition on a pattern whose dropped bit is set, which catches a design that rounds instead of truncating or forgets the exponent increment.
- Alignment distances of exactly 24, 25 and beyond, where a bad shift limit would leave stray low bits.
- Total cancellation of equal magnitudes with either sign arrangement, which must give +0 and not -0.
- The two saturating edges: sums of the largest finite values must become a signed infinity, and differences of the smallest normal values must flush to zero instead of wrapping the exponent.

Random traffic with idle gaps checks that results and valid flags stay aligned to their operations.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

   // how the normalize stage treats the raw magnitude
   typedef enum logic [1:0] {
      NK_ZERO  = 2'd0,
      NK_CARRY = 2'd1,
      NK_SHIFT = 2'd2
   } norm_kind_e;

   // sign handling chosen by the magnitude stage
   typedef enum logic [1:0] {
      MG_ADD      = 2'd0,
      MG_SUB_KEEP = 2'd1,
      MG_SUB_FLIP = 2'd2
   } mag_kind_e;

endpackage

// File: rtl/fpadd_cmp.sv
module fpadd_cmp #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [EXP_W+MAN_W:0]     in_a,
   input  logic [EXP_W+MAN_W:0]     in_b,
   input  logic                     in_sub,
   output logic                     o_valid,
   output logic                     o_big_s,
   output logic [EXP_W-1:0]         o_big_e,
   output logic [MAN_W:0]           o_big_m,
   output logic                     o_sml_s,
   output logic [MAN_W:0]           o_sml_m,
   output logic [EXP_W-1:0]         o_shamt
);
   localparam int W     = 1 + EXP_W + MAN_W;
   localparam int SIG_W = MAN_W + 1;

   logic             sa, sb;
   logic [EXP_W-1:0] ea, eb;
   logic [SIG_W-1:0] ma, mb;
   logic [EXP_W:0]   diff_ab, diff_ba;
   logic             cmp_sign;

   always_comb begin
      sa = in_a[W-1];
      sb = in_b[W-1] ^ in_sub;
      ea = in_a[W-2:MAN_W];
      eb = in_b[W-2:MAN_W];
      ma = (ea == '0) ? '0 : {1'b1, in_a[MAN_W-1:0]};
      mb = (eb == '0) ? '0 : {1'b1, in_b[MAN_W-1:0]};
      // two parallel subtractors; the borrow of A-B marks B as larger
      diff_ab  = {1'b0, ea} - {1'b0, eb};
      diff_ba  = {1'b0, eb} - {1'b0, ea};
      cmp_sign = diff_ab[EXP_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         o_valid <= 1'b0;
         o_big_s <= 1'b0;
         o_big_e <= '0;
         o_big_m <= '0;
         o_sml_s <= 1'b0;
         o_sml_m <= '0;
         o_shamt <= '0;
      end else begin
         o_valid <= in_valid;
         o_big_s <= cmp_sign ? sb : sa;
         o_big_e <= cmp_sign ? eb : ea;
         o_big_m <= cmp_sign ? mb : ma;
         o_sml_s <= cmp_sign ? sa : sb;
         o_sml_m <= cmp_sign ? ma : mb;
         o_shamt <= cmp_sign ? diff_ba[EXP_W-1:0] : diff_ab[EXP_W-1:0];
      end
   end

   // R3: a strictly larger B exponent becomes the reference exponent
   assert_swap_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (in_b[W-2:MAN_W] > in_a[W-2:MAN_W])) |=> (o_big_e == $past(in_b[W-2:MAN_W])));

   // R2: valid advances one stage per clock
   assert_valid_step_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> o_valid);
   assert_idle_step_R10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !o_valid);
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic               in_big_s,
   input  logic [EXP_W-1:0]   in_big_e,
   input  logic [MAN_W:0]     in_big_m,
   input  logic               in_sml_s,
   input  logic [MAN_W:0]     in_sml_m,
   input  logic [EXP_W-1:0]   in_shamt,
   output logic               o_valid,
   output logic               o_big_s,
   output logic [EXP_W-1:0]   o_big_e,
   output logic [MAN_W:0]     o_big_m,
   output logic [MAN_W:0]     o_al_m,
   output logic               o_eff_sub
);
   localparam int SIG_W = MAN_W + 1;
   localparam logic [EXP_W:0] SH_LIM = (EXP_W+1)'(SIG_W + 1);

   logic [SIG_W-1:0] shifted;
   logic             too_far;

   always_comb begin
      too_far = ({1'b0, in_shamt} >= SH_LIM);
      shifted = too_far ? '0 : (in_sml_m >> in_shamt);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         o_valid   <= 1'b0;
         o_big_s   <= 1'b0;
         o_big_e   <= '0;
         o_big_m   <= '0;
         o_al_m    <= '0;
         o_eff_sub <= 1'b0;
      end else begin
         o_valid   <= in_valid;
         o_big_s   <= in_big_s;
         o_big_e   <= in_big_e;
         o_big_m   <= in_big_m;
         o_al_m    <= shifted;
         o_eff_sub <= in_big_s ^ in_sml_s;
      end
   end

   // R4: far-apart operands leave nothing of the smaller mantissa
   assert_far_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ({1'b0, in_shamt} >= SH_LIM)) |=> (o_al_m == '0));

   // R4: alignment never grows the smaller mantissa
   assert_shift_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (o_al_m <= $past(in_sml_m)));
endmodule

// File: rtl/fpadd_mag.sv
module fpadd_mag
   import fpadd_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic               in_big_s,
   input  logic [EXP_W-1:0]   in_big_e,
   input  logic [MAN_W:0]     in_big_m,
   input  logic [MAN_W:0]     in_al_m,
   input  logic               in_eff_sub,
   output logic               o_valid,
   output logic               o_sign,
   output logic [EXP_W-1:0]   o_exp,
   output logic [MAN_W+1:0]   o_sum
);
   localparam int SIG_W = MAN_W + 1;
   localparam int SUM_W = SIG_W + 1;

   mag_kind_e        kind;
   logic [SUM_W-1:0] mag;
   logic             sgn;

   always_comb begin
      if (!in_eff_sub)
         kind = MG_ADD;
      else if (in_big_m >= in_al_m)
         kind = MG_SUB_KEEP;
      else
         kind = MG_SUB_FLIP;
      unique case (kind)
         MG_ADD: begin
            mag = {1'b0, in_big_m} + {1'b0, in_al_m};
            sgn = in_big_s;
         end
         MG_SUB_KEEP: begin
            mag = {1'b0, in_big_m} - {1'b0, in_al_m};
            sgn = in_big_s;
         end
         default: begin
            mag = {1'b0, in_al_m} - {1'b0, in_big_m};
            sgn = ~in_big_s;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         o_valid <= 1'b0;
         o_sign  <= 1'b0;
         o_exp   <= '0;
         o_sum   <= '0;
      end else begin
         o_valid <= in_valid;
         o_sign  <= sgn;
         o_exp   <= in_big_e;
         o_sum   <= mag;
      end
   end

   // R6: a magnitude subtraction cannot produce a carry
   assert_sub_no_carry_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_eff_sub) |=> !o_sum[SUM_W-1]);

   // R2: valid advances one stage per clock
   assert_mag_valid_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> o_valid);
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
   import fpadd_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic                   in_sign,
   input  logic [EXP_W-1:0]       in_exp,
   input  logic [MAN_W+1:0]       in_sum,
   output logic                   o_valid,
   output logic [EXP_W+MAN_W:0]   o_res
);
   localparam int W       = 1 + EXP_W + MAN_W;
   localparam int SIG_W   = MAN_W + 1;
   localparam int SUM_W   = SIG_W + 1;
   localparam int LZ_W    = $clog2(SIG_W + 1);
   localparam int NE_W    = EXP_W + 2;
   localparam int EXP_MAX = (1 << EXP_W) - 1;

   norm_kind_e              kind;
   logic [LZ_W-1:0]         lz;
   logic                    found;
   logic [SIG_W-1:0]        mnorm;
   logic signed [NE_W-1:0]  ne;
   logic [W-1:0]            res;

   // leading-zero count over the lower SIG_W bits
   always_comb begin
      lz    = '0;
      found = 1'b0;
      for (int i = SIG_W - 1; i >= 0; i--) begin
         if (!found) begin
            if (in_sum[i]) found = 1'b1;
            else           lz = lz + 1'b1;
         end
      end
   end

   always_comb begin
      if (in_sum == '0)
         kind = NK_ZERO;
      else if (in_sum[SUM_W-1])
         kind = NK_CARRY;
      else
         kind = NK_SHIFT;
      mnorm = '0;
      ne    = '0;
      unique case (kind)
         NK_CARRY: begin
            mnorm = in_sum[SUM_W-1:1];
            ne    = $signed({2'b00, in_exp} + NE_W'(1));
         end
         NK_SHIFT: begin
            mnorm = in_sum[SIG_W-1:0] << lz;
            ne    = $signed({2'b00, in_exp} - {{(NE_W-LZ_W){1'b0}}, lz});
         end
         default: begin
            mnorm = '0;
            ne    = '0;
         end
      endcase
      if (kind == NK_ZERO)
         res = '0;
      else if (ne >= $signed(NE_W'(EXP_MAX)))
         res = {in_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      else if (ne <= $signed(NE_W'(0)))
         res = '0;
      else
         res = {in_sign, ne[EXP_W-1:0], mnorm[MAN_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         o_valid <= 1'b0;
         o_res   <= '0;
      end else begin
         o_valid <= in_valid;
         o_res   <= res;
      end
   end

   // R7/R9: a zero exponent field only ever appears as +0
   assert_no_subnormal_R9: assert property (@(posedge clk) disable iff (rst)
      (o_valid && (o_res[W-2:MAN_W] == '0)) |-> (o_res == '0));

   // R8: saturated results carry a clean fraction
   assert_inf_clean_R8: assert property (@(posedge clk) disable iff (rst)
      (o_valid && (o_res[W-2:MAN_W] == {EXP_W{1'b1}})) |-> (o_res[MAN_W-1:0] == '0));

   // R7: a zero magnitude leaves as +0
   assert_zero_plus_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (in_sum == '0)) |=> (o_res == '0));

   // R10: idle cycles stay idle at the output
   assert_norm_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !o_valid);
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [EXP_W+MAN_W:0]   in_a,
   input  logic [EXP_W+MAN_W:0]   in_b,
   input  logic                   in_sub,
   output logic                   out_valid,
   output logic [EXP_W+MAN_W:0]   out_res
);
   localparam int SIG_W = MAN_W + 1;
   localparam int SUM_W = SIG_W + 1;

   generate
      if (EXP_W < 3) begin : g_bad_exp
         $error("fp_add_pipe: EXP_W must be at least 3");
      end
      if (MAN_W < 2) begin : g_bad_man
         $error("fp_add_pipe: MAN_W must be at least 2");
      end
      if ((SIG_W + 1) >= (1 << EXP_W)) begin : g_bad_ratio
         $error("fp_add_pipe: exponent range too small for the mantissa width");
      end
   endgenerate

   logic             c_valid, c_big_s, c_sml_s;
   logic [EXP_W-1:0] c_big_e, c_shamt;
   logic [SIG_W-1:0] c_big_m, c_sml_m;

   logic             a_valid, a_big_s, a_eff_sub;
   logic [EXP_W-1:0] a_big_e;
   logic [SIG_W-1:0] a_big_m, a_al_m;

   logic             m_valid, m_sign;
   logic [EXP_W-1:0] m_exp;
   logic [SUM_W-1:0] m_sum;

   fpadd_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
      .o_valid(c_valid), .o_big_s(c_big_s), .o_big_e(c_big_e), .o_big_m(c_big_m),
      .o_sml_s(c_sml_s), .o_sml_m(c_sml_m), .o_shamt(c_shamt)
   );

   fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
      .clk(clk), .rst(rst), .in_valid(c_valid), .in_big_s(c_big_s), .in_big_e(c_big_e),
      .in_big_m(c_big_m), .in_sml_s(c_sml_s), .in_sml_m(c_sml_m), .in_shamt(c_shamt),
      .o_valid(a_valid), .o_big_s(a_big_s), .o_big_e(a_big_e), .o_big_m(a_big_m),
      .o_al_m(a_al_m), .o_eff_sub(a_eff_sub)
   );

   fpadd_mag #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mag (
      .clk(clk), .rst(rst), .in_valid(a_valid), .in_big_s(a_big_s), .in_big_e(a_big_e),
      .in_big_m(a_big_m), .in_al_m(a_al_m), .in_eff_sub(a_eff_sub),
      .o_valid(m_valid), .o_sign(m_sign), .o_exp(m_exp), .o_sum(m_sum)
   );

   fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
      .clk(clk), .rst(rst), .in_valid(m_valid), .in_sign(m_sign), .in_exp(m_exp),
      .in_sum(m_sum), .o_valid(out_valid), .o_res(out_res)
   );

   // R2: reset leaves the output idle on the next edge
   assert_reset_idle_R2: assert property (@(posedge clk)
      rst |=> !out_valid);
endmodule

// File: tb/fp_add_pipe_bench.sv
`timescale 1ns/1ps
module fp_add_pipe_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic        in_sub = 1'b0;
   logic        out_valid;
   logic [31:0] out_res;

   int total = 0;
   int bad   = 0;

   logic [32:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;   // 250 MHz

   fp_add_pipe u_fp_add_pipe (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .in_sub(in_sub), .out_valid(out_valid), .out_res(out_res)
   );

   // behavioural model of the requirements
   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic s);
      int     ea, eb, eg, es, d, e;
      longint ma, mb, mg, ms, mag;
      logic   sa, sb, sg, ss, sr;
      sa = a[31]; sb = b[31] ^ s;
      ea = int'(a[30:23]); eb = int'(b[30:23]);
      ma = (ea == 0) ? 0 : (longint'(1) << 23) | longint'(a[22:0]);
      mb = (eb == 0) ? 0 : (longint'(1) << 23) | longint'(b[22:0]);
      if (eb > ea) begin eg = eb; mg = mb; sg = sb; es = ea; ms = ma; ss = sa; end
      else         begin eg = ea; mg = ma; sg = sa; es = eb; ms = mb; ss = sb; end
      d = eg - es;
      ms = (d >= 25) ? 0 : (ms >> d);
      if (sg == ss)      begin mag = mg + ms; sr = sg;  end
      else if (mg >= ms) begin mag = mg - ms; sr = sg;  end
      else               begin mag = ms - mg; sr = ~sg; end
      if (mag == 0) return 32'h0;
      e = eg;
      while (mag >= (longint'(1) << 24)) begin mag = mag >> 1; e++; end
      while (mag <  (longint'(1) << 23)) begin mag = mag << 1; e--; end
      if (e >= 255) return {sr, 8'hff, 23'h0};
      if (e <= 0)   return 32'h0;
      return {sr, 8'(e), 23'(mag)};
   endfunction

   task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic [31:0] expv, input string tag);
      logic [32:0] ent;
      string       t;
      in_valid = v; in_a = a; in_b = b; in_sub = s;
      exp_q.push_back({v, expv});
      tag_q.push_back(tag);
      @(negedge clk);
      if (exp_q.size() == 4) begin
         ent = exp_q.pop_front();
         t   = tag_q.pop_front();
         total++;
         if (out_valid !== ent[32]) begin
            bad++;
            $display("FAIL %s valid actual=%b expected=%b", t, out_valid, ent[32]);
         end else if (ent[32] && out_res !== ent[31:0]) begin
            bad++;
            $display("FAIL %s result actual=%08h expected=%08h", t, out_res, ent[31:0]);
         end
      end
   endtask

   task automatic op(input logic [31:0] a, input logic [31:0] b, input logic s,
                     input logic [31:0] expv, input string tag);
      step(1'b1, a, b, s, expv, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] ra, rb;
      logic        rs;
      repeat (3) @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R2 reset actual=%b expected=0", out_valid);
      end
      rst = 1'b0;

      op(32'h3f800000, 32'h3f800000, 1'b0, 32'h40000000, "R5 1+1");
      op(32'h3fc00000, 32'h40200000, 1'b0, 32'h40800000, "R5 1.5+2.5");
      op(32'h3f800003, 32'h3f800000, 1'b0, 32'h40000001, "R5 truncation");
      op(32'h40400000, 32'h40000000, 1'b1, 32'h3f800000, "R6 3-2");
      op(32'h00800001, 32'h00800000, 1'b1, 32'h00000000, "R9 underflow");
      op(32'h3f800000, 32'h3fc00000, 1'b1, 32'hbf000000, "R3 1-1.5");
      op(32'hbfc00000, 32'h3f800000, 1'b0, 32'hbf000000, "R3 -1.5+1");
      op(32'h40a00000, 32'h40a00000, 1'b1, 32'h00000000, "R7 5-5");
      idle("R10 gap");
      op(32'hc0a00000, 32'h40a00000, 1'b0, 32'h00000000, "R7 -5+5");
      op(32'h00000001, 32'h3f800000, 1'b0, 32'h3f800000, "R7 tiny operand");
      op(32'h3f800000, 32'h30800000, 1'b0, 32'h3f800000, "R4 far");
      op(32'h40000000, 32'h33800000, 1'b1, 32'h40000000, "R4 shift 25");
      op(32'h3f800000, 32'h33800000, 1'b0, 32'h3f800000, "R4 shift 24");
      op(32'h3f800000, 32'h34000000, 1'b0, 32'h3f800001, "R4 shift 23");
      op(32'h7f7fffff, 32'h7f7fffff, 1'b0, 32'h7f800000, "R8 +max");
      op(32'hff7fffff, 32'h7f7fffff, 1'b1, 32'hff800000, "R8 -max");
      idle("R10 gap");
      idle("R10 gap");
      op(32'h40490fdb, 32'hc0490fdb, 1'b1, model(32'h40490fdb, 32'hc0490fdb, 1'b1), "R1 sub of negative");

      for (int i = 0; i < 400; i++) begin
         ra = $urandom; rb = $urandom; rs = 1'($urandom);
         if ((i % 3) == 0) rb = {rb[31], ra[30:23] - 8'($urandom % 3), rb[22:0]};
         if ((i % 11) == 5) idle("R10 random gap");
         else op(ra, rb, rs, model(ra, rb, rs), "R1 random");
      end

      repeat (4) idle("R10 flush");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule